// File: doc/BRIEF.md
# At-Memory Atomic Fetch-Op Unit

This block sits next to a memory module and carries out atomic operations on synchronization words where they are stored. No caches and no coherence traffic are involved. A requester issues an ordinary load or store into a dedicated uncacheable address window. The offset bits of that address name the operation. The unit serializes requests, performs one indivisible read-modify-write on the selected word and returns exactly one response.

Two additions make common synchronization patterns cheaper. The first is a single-entry result cache that remembers the word touched most recently, so a requester spinning on a flag gets each poll answered one cycle sooner. The second is a small bank of operand registers that supplies the third argument of compare-and-swap, which lets that operation travel as a plain two-argument store. A write-then-read operation resets a flag and returns its fresh contents in one transaction, which is the usual release step.

Top module: `fetchop_unit`

## Requirements
- R1: The request address is split into four fields. `req_addr[2:0]` is ignored. `req_addr[6:3]` is the opcode. `req_addr[10:7]` is the word index. `req_addr[15:11]` must equal the window identifier `WIN_ID` (default 5'h15).
- R2: The plain operations behave as follows. Opcode 0 (read) returns the word and leaves it unchanged. Opcode 1 (write) stores the write data and returns the previous contents. Opcode 8 (write-then-read) stores the write data and returns the contents after the write.
- R3: Opcode 2 stores the word ANDed with the write data, and opcode 3 stores the word ORed with it. Both return the value held before the change.
- R4: Opcode 4 adds one to the word and opcode 5 subtracts one, both modulo 2^64 with no saturation. Both return the value held before the change.
- R5: Opcode 6 (swap-with-zero) returns the old word and clears it.
- R6: Opcode 7 is compare-and-swap.
  - Write data bits [63:62] select the operand register that holds the compare value.
  - If the word equals that register, the word becomes write data bits [61:0] zero-extended, and `rsp_cas_ok` is 1.
  - Otherwise the word is unchanged and `rsp_cas_ok` is 0.
  - In both cases the old word is returned.
- R7: Opcode 9 loads the write data into the operand register selected by the low two bits of the word-index field. It returns zero, touches no storage word and leaves the result cache unchanged.
- R8: An undefined opcode (10 to 15), or an address outside the window, changes no state. It returns `rsp_data` = 0 with `rsp_err` = 1 and `rsp_cas_ok` = 0.
- R9: Only one request is in flight at a time.
  - `req_ready` is low from acceptance until the response has been taken.
  - A response held by `rsp_ready` low keeps its value stable.
- R10: Timing is counted from the clock edge that accepts a request. A read that hits the result cache presents `rsp_valid` one cycle later. Every other request presents it two cycles later.
- R11: Every in-window operation with opcode 0 to 8 refreshes the result cache with that word's index and its post-operation value. A following read of the same word therefore hits and sees the new value, while a read of any other word misses.
- R12: After reset:
  - All storage words and operand registers read as zero.
  - The result cache is invalid, so the first read misses.
  - `req_ready` is 1 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | ADDR_W (16) | Window, word index, opcode and ignored byte bits |
| req_wdata | input | DATA_W (64) | Operand data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | DATA_W (64) | Result value |
| rsp_cas_ok | output | 1 | Compare-and-swap succeeded |
| rsp_err | output | 1 | Undefined opcode or address outside the window |

## Verification
Each request's result is due at a fixed distance from its accepting edge: one cycle for a read that hits the result cache, two cycles for everything else. The driver records the accepting edge. The monitor measures the gap to the first cycle in which `rsp_valid` is high, and compares that gap with the latency the reference model predicted from its own copy of the cache state. Outputs are sampled on the falling edge, so every comparison happens half a cycle after the register that produced the value has updated. One stalled response tests that the unit holds its output and blocks new requests until `rsp_ready` returns.

// File: rtl/fop_pkg.sv
package fop_pkg;
   localparam int unsigned OP_W   = 4;
   localparam int unsigned OP_LSB = 3;

   typedef enum logic [OP_W-1:0] {
      OP_RD     = 4'd0,
      OP_WR     = 4'd1,
      OP_AND    = 4'd2,
      OP_OR     = 4'd3,
      OP_INC    = 4'd4,
      OP_DEC    = 4'd5,
      OP_SWZ    = 4'd6,
      OP_CAS    = 4'd7,
      OP_WRD    = 4'd8,
      OP_SETOPR = 4'd9
   } fop_op_e;

   typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_RESP} fop_state_e;

   function automatic logic op_defined(input logic [OP_W-1:0] c);
      return c <= OP_SETOPR;
   endfunction

   function automatic logic op_on_word(input logic [OP_W-1:0] c);
      return c <= OP_WRD;
   endfunction
endpackage

// File: rtl/fop_decode.sv
module fop_decode
   import fop_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned WIN_W  = 5,
   parameter logic [WIN_W-1:0] WIN_ID = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [OP_W-1:0]   op,
   output logic [IDX_W-1:0]  idx,
   output logic              legal
);
   localparam int unsigned IDX_LSB = OP_LSB + OP_W;
   localparam int unsigned WIN_LSB = IDX_LSB + IDX_W;

   logic in_win;

   always_comb begin
      op     = addr[OP_LSB +: OP_W];
      idx    = addr[IDX_LSB +: IDX_W];
      in_win = (addr[WIN_LSB +: WIN_W] == WIN_ID);
      legal  = in_win && op_defined(op);
   end
endmodule

// File: rtl/fop_alu.sv
module fop_alu
   import fop_pkg::*;
#(
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned OPSEL_W = 2
) (
   input  logic [OP_W-1:0]   op,
   input  logic [DATA_W-1:0] old_val,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] cmp_val,
   output logic [DATA_W-1:0] new_val,
   output logic              wr_en,
   output logic [DATA_W-1:0] result,
   output logic              cas_ok
);
   localparam int unsigned SWAP_W = DATA_W - OPSEL_W;

   always_comb begin
      new_val = old_val;
      wr_en   = 1'b0;
      result  = old_val;
      cas_ok  = 1'b0;
      unique case (op)
         OP_RD:  ;
         OP_WR:  begin new_val = wdata;              wr_en = 1'b1; end
         OP_AND: begin new_val = old_val & wdata;    wr_en = 1'b1; end
         OP_OR:  begin new_val = old_val | wdata;    wr_en = 1'b1; end
         OP_INC: begin new_val = old_val + 1'b1;     wr_en = 1'b1; end
         OP_DEC: begin new_val = old_val - 1'b1;     wr_en = 1'b1; end
         OP_SWZ: begin new_val = '0;                 wr_en = 1'b1; end
         OP_CAS: begin
            if (old_val == cmp_val) begin
               new_val = {{OPSEL_W{1'b0}}, wdata[SWAP_W-1:0]};
               wr_en   = 1'b1;
               cas_ok  = 1'b1;
            end
         end
         OP_WRD: begin new_val = wdata; wr_en = 1'b1; result = wdata; end
         default: result = '0;
      endcase
   end
endmodule

// File: rtl/fop_lastcache.sv
module fop_lastcache #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  look_idx,
   output logic              hit,
   output logic [DATA_W-1:0] hit_val,
   input  logic              upd_en,
   input  logic [IDX_W-1:0]  upd_idx,
   input  logic [DATA_W-1:0] upd_val
);
   logic              ent_vld;
   logic [IDX_W-1:0]  ent_idx;
   logic [DATA_W-1:0] ent_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_vld <= 1'b0;
         ent_idx <= '0;
         ent_val <= '0;
      end else if (upd_en) begin
         ent_vld <= 1'b1;
         ent_idx <= upd_idx;
         ent_val <= upd_val;
      end
   end

   assign hit     = ent_vld && (ent_idx == look_idx);
   assign hit_val = ent_val;
endmodule

// File: rtl/fetchop_unit.sv
module fetchop_unit
   import fop_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned WORDS     = 16,
   parameter int unsigned OPREGS    = 4,
   parameter bit          HIT_CACHE = 1'b1,
   parameter logic [4:0]  WIN_ID    = 5'h15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_cas_ok,
   output logic              rsp_err
);
   localparam int unsigned IDX_W   = $clog2(WORDS);
   localparam int unsigned OPSEL_W = $clog2(OPREGS);
   localparam int unsigned WIN_LSB = OP_LSB + OP_W + IDX_W;
   localparam int unsigned WIN_W   = ADDR_W - WIN_LSB;

   if (WIN_W != 5) begin : g_bad_win
      $error("ADDR_W must leave exactly five window bits above the word index");
   end
   if ((1 << IDX_W) != WORDS) begin : g_bad_words
      $error("WORDS must be a power of two");
   end
   if (OPSEL_W < 1 || OPSEL_W > IDX_W) begin : g_bad_opregs
      $error("OPREGS must be between 2 and WORDS");
   end
   if (DATA_W <= 2 * OPSEL_W) begin : g_bad_data
      $error("DATA_W too narrow for the operand selector");
   end

   fop_state_e state;

   logic [OP_W-1:0]   live_op;
   logic [IDX_W-1:0]  live_idx;
   logic              live_legal;

   logic [OP_W-1:0]   q_op;
   logic [IDX_W-1:0]  q_idx;
   logic              q_legal;
   logic [DATA_W-1:0] q_data;

   logic [DATA_W-1:0] mem [WORDS];
   logic [DATA_W-1:0] opr_q [OPREGS];

   logic [DATA_W-1:0] mem_old, cmp_val, alu_new, alu_res;
   logic              alu_wr, alu_ok;
   logic [OPSEL_W-1:0] cas_sel;

   logic              c_hit;
   logic [DATA_W-1:0] c_val;
   logic              c_upd;
   logic [DATA_W-1:0] c_upd_val;

   logic accept, fast_hit, exec_word, opr_we;

   fop_decode #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WIN_W(WIN_W), .WIN_ID(WIN_ID)
   ) u_dec (
      .addr(req_addr), .op(live_op), .idx(live_idx), .legal(live_legal)
   );

   assign req_ready = (state == ST_IDLE);
   assign rsp_valid = (state == ST_RESP);
   assign accept    = req_valid && req_ready;
   assign fast_hit  = live_legal && (live_op == OP_RD) && c_hit;

   assign mem_old   = mem[q_idx];
   assign cas_sel   = q_data[DATA_W-1 -: OPSEL_W];
   assign cmp_val   = opr_q[cas_sel];
   assign exec_word = (state == ST_EXEC) && q_legal && op_on_word(q_op);
   assign opr_we    = (state == ST_EXEC) && q_legal && (q_op == OP_SETOPR);
   assign c_upd     = exec_word;
   assign c_upd_val = alu_wr ? alu_new : mem_old;

   fop_alu #(.DATA_W(DATA_W), .OPSEL_W(OPSEL_W)) u_alu (
      .op(q_op), .old_val(mem_old), .wdata(q_data), .cmp_val(cmp_val),
      .new_val(alu_new), .wr_en(alu_wr), .result(alu_res), .cas_ok(alu_ok)
   );

   if (HIT_CACHE) begin : g_cache
      fop_lastcache #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_lc (
         .clk(clk), .rst_n(rst_n),
         .look_idx(live_idx), .hit(c_hit), .hit_val(c_val),
         .upd_en(c_upd), .upd_idx(q_idx), .upd_val(c_upd_val)
      );
   end else begin : g_nocache
      assign c_hit = 1'b0;
      assign c_val = '0;
   end

   for (genvar r = 0; r < OPREGS; r++) begin : g_opr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            opr_q[r] <= '0;
         else if (opr_we && (q_idx[OPSEL_W-1:0] == OPSEL_W'(r)))
            opr_q[r] <= q_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      end else if (exec_word && alu_wr) begin
         mem[q_idx] <= alu_new;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         q_op       <= '0;
         q_idx      <= '0;
         q_legal    <= 1'b0;
         q_data     <= '0;
         rsp_data   <= '0;
         rsp_cas_ok <= 1'b0;
         rsp_err    <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (accept) begin
               q_op    <= live_op;
               q_idx   <= live_idx;
               q_legal <= live_legal;
               q_data  <= req_wdata;
               if (fast_hit) begin
                  rsp_data   <= c_val;
                  rsp_cas_ok <= 1'b0;
                  rsp_err    <= 1'b0;
                  state      <= ST_RESP;
               end else begin
                  state      <= ST_EXEC;
               end
            end
            ST_EXEC: begin
               rsp_data   <= q_legal ? alu_res : '0;
               rsp_cas_ok <= q_legal && alu_ok;
               rsp_err    <= !q_legal;
               state      <= ST_RESP;
            end
            ST_RESP: if (rsp_ready) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fop_checker.sv
module fop_checker #(
   parameter int unsigned DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [DATA_W-1:0] rsp_data,
   input logic              rsp_cas_ok,
   input logic              rsp_err
);
   assert_single_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_ready && rsp_valid));

   assert_accept_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_hold_response_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)
                                     && $stable(rsp_err) && $stable(rsp_cas_ok)));

   assert_error_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_data == '0 && !rsp_cas_ok));
endmodule

bind fetchop_unit fop_checker #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
   .rsp_cas_ok(rsp_cas_ok), .rsp_err(rsp_err)
);

// File: tb/fetchop_unit_test.sv
module fetchop_unit_test;
   localparam logic [4:0] WIN = 5'h15;

   typedef struct {
      logic [63:0] data;
      logic        ok;
      logic        err;
      int          lat;
      int          req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_addr = '0;
   logic [63:0] req_wdata = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [63:0] rsp_data;
   logic        rsp_cas_ok;
   logic        rsp_err;

   int   vectors = 0;
   int   miscompares = 0;
   int   cyc = 0;
   int   acc_cyc = 0;
   int   lat_meas = 0;
   bit   lat_taken = 0;
   bit   done = 0;
   exp_t sb[$];

   logic [63:0] m_mem [16];
   logic [63:0] m_opr [4];
   bit          m_cv = 0;
   logic [3:0]  m_ci = '0;

   fetchop_unit uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_cas_ok(rsp_cas_ok),
      .rsp_err(rsp_err)
   );

   always #4 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000 && !done) begin
         miscompares = miscompares + 1;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (rsp_valid && !lat_taken) begin
         lat_meas  = cyc - acc_cyc + 1;
         lat_taken = 1;
      end
      if (rsp_valid && rsp_ready) begin
         vectors = vectors + 1;
         if (sb.size() == 0) begin
            miscompares = miscompares + 1;
            $display("FAIL R9: actual=unexpected response expected=none");
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (rsp_data !== e.data || rsp_cas_ok !== e.ok || rsp_err !== e.err
                || lat_meas != e.lat) begin
               miscompares = miscompares + 1;
               $display("FAIL R%0d: actual data=%h ok=%b err=%b lat=%0d expected data=%h ok=%b err=%b lat=%0d",
                        e.req, rsp_data, rsp_cas_ok, rsp_err, lat_meas,
                        e.data, e.ok, e.err, e.lat);
            end
         end
         lat_taken = 0;
      end
   end

   task automatic check(input bit cond, input int req, input logic [63:0] act,
                        input logic [63:0] expv);
      vectors = vectors + 1;
      if (!cond) begin
         miscompares = miscompares + 1;
         $display("FAIL R%0d: actual=%h expected=%h", req, act, expv);
      end
   endtask

   // Reference model from the requirements, then drive one request.
   task automatic send(input logic [4:0] win, input logic [3:0] idx,
                       input logic [3:0] op, input logic [63:0] wd,
                       input int req, input logic [2:0] lowb = 3'b000);
      exp_t e;
      logic [63:0] old;
      e.data = '0; e.ok = 0; e.err = 0; e.lat = 2; e.req = req;
      if (win != WIN || op > 4'd9) begin
         e.err = 1;
      end else if (op == 4'd9) begin
         m_opr[idx[1:0]] = wd;
      end else begin
         old = m_mem[idx];
         e.data = old;
         if (op == 4'd0 && m_cv && m_ci == idx) e.lat = 1;
         case (op)
            4'd1: m_mem[idx] = wd;
            4'd2: m_mem[idx] = old & wd;
            4'd3: m_mem[idx] = old | wd;
            4'd4: m_mem[idx] = old + 64'd1;
            4'd5: m_mem[idx] = old - 64'd1;
            4'd6: m_mem[idx] = 64'd0;
            4'd7: if (old == m_opr[wd[63:62]]) begin
                     m_mem[idx] = {2'b00, wd[61:0]};
                     e.ok = 1;
                  end
            4'd8: begin m_mem[idx] = wd; e.data = wd; end
            default: ;
         endcase
         m_cv = 1; m_ci = idx;
      end
      sb.push_back(e);
      @(negedge clk);
      req_addr  = {win, idx, op, lowb};
      req_wdata = wd;
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      acc_cyc = cyc + 1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 16; i++) m_mem[i] = '0;
      for (int i = 0; i < 4; i++) m_opr[i] = '0;
      repeat (3) @(negedge clk);
      // R12: idle after reset
      check(req_ready === 1'b1 && rsp_valid === 1'b0, 12, {62'd0, req_ready, rsp_valid}, 64'h2);
      rst_n = 1'b1;
      @(negedge clk);

      send(WIN, 4'd3, 4'd0, '0, 12);                          // R12 first read misses, word zero
      send(WIN, 4'd3, 4'd0, '0, 11);                          // R11 repeat read hits
      send(WIN, 4'd5, 4'd7, {2'b01, 62'h0abc}, 12);           // R12 operand register zero -> CAS succeeds
      send(WIN, 4'd5, 4'd0, '0, 6);                           // R6 read result of CAS (hit)

      send(WIN, 4'd2, 4'd1, 64'hdead_beef_0123_4567, 2);      // R2 write returns old
      send(WIN, 4'd2, 4'd0, '0, 11);                          // R11 hit after write
      send(WIN, 4'd4, 4'd8, 64'h0f0f_0000_1111_2222, 2);      // R2 write-then-read
      send(WIN, 4'd2, 4'd0, '0, 11);                          // R11 other word misses

      send(WIN, 4'd2, 4'd2, 64'hffff_0000_ffff_00f0, 3);      // R3 AND
      send(WIN, 4'd2, 4'd3, 64'h0000_1234_0000_0008, 3);      // R3 OR
      send(WIN, 4'd2, 4'd0, '0, 3);

      send(WIN, 4'd7, 4'd1, 64'hffff_ffff_ffff_ffff, 4);
      send(WIN, 4'd7, 4'd4, '0, 4);                           // R4 increment wraps to zero
      send(WIN, 4'd7, 4'd5, '0, 4);                           // R4 decrement from zero wraps
      send(WIN, 4'd7, 4'd0, '0, 4);

      send(WIN, 4'd8, 4'd1, 64'h55, 5);
      send(WIN, 4'd8, 4'd6, '0, 5);                           // R5 swap-with-zero
      send(WIN, 4'd8, 4'd0, '0, 5);

      send(WIN, 4'd6, 4'd9, 64'h1234, 7);                     // R7 index 6 -> operand register 2
      send(WIN, 4'd8, 4'd0, '0, 7);                           // R7 cache untouched: still hits
      send(WIN, 4'd6, 4'd0, '0, 7);                           // R7 word 6 untouched

      send(WIN, 4'd9, 4'd7, {2'b10, 62'h99}, 6);              // R6 CAS mismatch fails
      send(WIN, 4'd9, 4'd1, 64'h1234, 6);
      send(WIN, 4'd9, 4'd7, {2'b10, 62'h99}, 6);              // R6 CAS match succeeds
      send(WIN, 4'd9, 4'd0, '0, 6);

      send(WIN, 4'd2, 4'd12, 64'h1, 8);                       // R8 undefined opcode
      send(5'h14, 4'd2, 4'd1, 64'h7, 8);                      // R8 outside window
      send(5'h14, 4'd2, 4'd0, '0, 8);
      send(WIN, 4'd2, 4'd0, '0, 8);                           // R8 word unchanged

      send(WIN, 4'd2, 4'd0, '0, 1, 3'b111);                   // R1 byte bits ignored
      send(WIN, 4'd15, 4'd1, 64'h00ab_cdef, 1);               // R1 top word index
      send(WIN, 4'd15, 4'd0, '0, 1, 3'b101);

      wait (sb.size() == 0);
      @(negedge clk);
      rsp_ready = 1'b0;
      send(WIN, 4'd15, 4'd4, '0, 9);                          // R9 stalled response
      repeat (3) @(negedge clk);
      check(rsp_valid === 1'b1 && req_ready === 1'b0, 9,
            {62'd0, rsp_valid, req_ready}, 64'h2);
      rsp_ready = 1'b1;
      send(WIN, 4'd15, 4'd0, '0, 10);                         // R10 hit latency after stall

      wait (sb.size() == 0);
      repeat (2) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule